// File: doc/BRIEF.md
# Two-Sided Mailbox Register Bank

This block holds eight 16-bit message registers that a host processor and a pair of secondary processors use to hand data to each other. Both sides have a simple synchronous register port with write and read strobes, a byte address, per-byte write enables, write data and read data. The secondary processors reach the bank through one shared port. Arbitration between the two secondaries happens outside the bank.

Each register carries two "posted" flags, one for each writing side. A write only counts when it actually changes the contents of the lanes it enables. Such a write stores the new data and raises the writer's posted flag. A read from the opposite side clears that flag. A host write that changes a register also sends a one-cycle wake pulse to both secondary processors, so that a processor polling for mail can resume. Posted flags are driven straight from flip-flops. Read data comes back one cycle after the read strobe.

Each register is its own cell with a small write-source selector. For each register, on each cycle, it picks one of three values: `WSRC_NONE` (no committed write), `WSRC_HOST` (the host's write commits) or `WSRC_SEC` (the secondary's write commits). The selector chooses `WSRC_SEC` whenever the secondary side writes the register and changes it. It chooses `WSRC_HOST` when only the host writes and changes it. Otherwise it chooses `WSRC_NONE`. The choice is made again every cycle, so there is no sequencing across cycles.

Top module: `mbx_bank`

## Requirements
- R1: The registers sit at byte offsets 0x20 to 0x2F of a 6-bit address. The register index is address bits [3:1], so 0x2E and 0x2F both reach register 7. A write outside that window changes nothing, and a read outside it returns 0.
- R2: A host write that changes a register stores the data. The new value can be read back, and the register's host-posted flag is set, from the cycle after the write.
- R3: A host write whose enabled lanes all equal the current contents is dropped. The register is not changed, the host-posted flag is not set and no wake pulse is sent.
- R4: A host write that changes a register drives both bits of `wake` high for exactly the one cycle that follows the write.
- R5: A host read returns the register value in the cycle after the read strobe. It also clears that register's secondary-posted flag.
- R6: Byte enable bit 1 selects data bits 15:8 and bit 0 selects bits 7:0. Only enabled lanes are written, and the equality test in R3 looks only at enabled lanes.
- R7: Secondary writes behave like host writes, but they set the secondary-posted flag and send no wake pulse. A secondary read returns the value one cycle later and clears the host-posted flag.
- R8: If both sides write the same register in the same cycle, the host write is discarded. The secondary write is applied by its own rules, and the register's host-posted flag is cleared.
- R9: Reset, active low, clears every register and every posted flag.
- R10: If one cycle holds both a committed write that sets a posted flag and a read that would clear that flag, the flag ends up set. The read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_addr | input | 6 | Host byte address |
| h_be | input | 2 | Host byte enables (bit 1 = data bits 15:8) |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data, one cycle after the strobe |
| s_wr | input | 1 | Secondary write strobe |
| s_rd | input | 1 | Secondary read strobe |
| s_addr | input | 6 | Secondary byte address |
| s_be | input | 2 | Secondary byte enables |
| s_wdata | input | 16 | Secondary write data |
| s_rdata | output | 16 | Secondary read data, one cycle after the strobe |
| h_posted | output | 8 | Host-posted flag for each register |
| s_posted | output | 8 | Secondary-posted flag for each register |
| wake | output | 2 | Wake pulse, one bit per secondary processor |

## Verification
Every result of this block is due at the first clock edge after the cycle that carries the stimulus. Read data, posted flags and the wake pulse all appear then. The wake bits are also checked to be low again one edge later. The driver presents each operation at a falling edge and queues the expected value tagged with that due cycle. The monitor samples a quarter period after each rising edge and compares only the items that fall due in that cycle. A late or missing result therefore surfaces as a mismatch. Checks that a dropped write had no effect, and checks of the read-versus-set ordering, go through the posted outputs and a later read of the register.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Which side, if any, commits a write to a register this cycle.
    typedef enum logic [1:0] {
        WSRC_NONE = 2'd0,
        WSRC_HOST = 2'd1,
        WSRC_SEC  = 2'd2
    } wsrc_e;

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode #(
    parameter int AW   = 6,
    parameter int NREG = 8,
    parameter int BASE = 32
) (
    input  logic                    wr,
    input  logic                    rd,
    input  logic [AW-1:0]           addr,
    output logic [NREG-1:0]         wr_sel,
    output logic [NREG-1:0]         rd_sel
);
    localparam int IDXW = $clog2(NREG);
    localparam int LO   = IDXW + 1;
    localparam logic [AW-1:0] BASE_V = AW'(BASE);

    logic            hit;
    logic [IDXW-1:0] idx;

    assign hit = (addr[AW-1:LO] == BASE_V[AW-1:LO]);
    assign idx = addr[LO-1:1];

    for (genvar i = 0; i < NREG; i++) begin : g_sel
        assign wr_sel[i] = wr && hit && (idx == IDXW'(i));
        assign rd_sel[i] = rd && hit && (idx == IDXW'(i));
    end

endmodule

// File: rtl/mbx_cell.sv
module mbx_cell
    import mbx_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                h_we,
    input  logic [DW/8-1:0]     h_be,
    input  logic [DW-1:0]       h_wd,
    input  logic                s_we,
    input  logic [DW/8-1:0]     s_be,
    input  logic [DW-1:0]       s_wd,
    input  logic                h_re,
    input  logic                s_re,
    output logic [DW-1:0]       q,
    output logic                h_dirty,
    output logic                s_dirty,
    output logic                h_commit
);
    localparam int LANES = DW / 8;

    logic [DW-1:0] h_mask, s_mask;
    logic [DW-1:0] h_merge, s_merge;
    logic          h_diff, s_diff;
    wsrc_e         src;
    logic [DW-1:0] q_n;
    logic          hd_n, sd_n;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign h_mask[l*8 +: 8] = {8{h_be[l]}};
        assign s_mask[l*8 +: 8] = {8{s_be[l]}};
    end

    assign h_diff  = |((h_wd ^ q) & h_mask);
    assign s_diff  = |((s_wd ^ q) & s_mask);
    assign h_merge = (h_wd & h_mask) | (q & ~h_mask);
    assign s_merge = (s_wd & s_mask) | (q & ~s_mask);

    // Source selector: the secondary side owns the register whenever it writes.
    always_comb begin
        if (s_we && s_diff)
            src = WSRC_SEC;
        else if (h_we && !s_we && h_diff)
            src = WSRC_HOST;
        else
            src = WSRC_NONE;
    end

    always_comb begin
        q_n  = q;
        hd_n = h_dirty & ~s_re;
        sd_n = s_dirty & ~h_re;
        unique case (src)
            WSRC_HOST: begin
                q_n  = h_merge;
                hd_n = 1'b1;
            end
            WSRC_SEC: begin
                q_n  = s_merge;
                sd_n = 1'b1;
            end
            default: ;
        endcase
        if (h_we && s_we)
            hd_n = 1'b0;
    end

    assign h_commit = (src == WSRC_HOST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            h_dirty <= 1'b0;
            s_dirty <= 1'b0;
        end else begin
            q       <= q_n;
            h_dirty <= hd_n;
            s_dirty <= sd_n;
        end
    end

    // R3: an unchanged host write leaves the register alone
    a_r3_same_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (h_we && !s_we && (((h_wd ^ q) & h_mask) == '0)) |=> (q == $past(q)));

    // R2: a committed host write marks the register as posted by the host
    a_r2_host_post: assert property (@(posedge clk) disable iff (!rst_n)
        h_commit |=> h_dirty);

    // R8: a same-cycle clash leaves the host flag clear
    a_r8_clash_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (h_we && s_we) |=> !h_dirty);

    // R5: a host read with no secondary write drops the secondary flag
    a_r5_hread_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (h_re && !s_we) |=> !s_dirty);

    // R7: a secondary read with no host write drops the host flag
    a_r7_sread_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (s_re && !h_we) |=> !h_dirty);

endmodule

// File: rtl/mbx_bank.sv
module mbx_bank #(
    parameter int AW   = 6,
    parameter int DW   = 16,
    parameter int NREG = 8,
    parameter int BASE = 32,
    parameter int NSEC = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                h_wr,
    input  logic                h_rd,
    input  logic [AW-1:0]       h_addr,
    input  logic [DW/8-1:0]     h_be,
    input  logic [DW-1:0]       h_wdata,
    output logic [DW-1:0]       h_rdata,
    input  logic                s_wr,
    input  logic                s_rd,
    input  logic [AW-1:0]       s_addr,
    input  logic [DW/8-1:0]     s_be,
    input  logic [DW-1:0]       s_wdata,
    output logic [DW-1:0]       s_rdata,
    output logic [NREG-1:0]     h_posted,
    output logic [NREG-1:0]     s_posted,
    output logic [NSEC-1:0]     wake
);
    logic [NREG-1:0] h_wsel, h_rsel, s_wsel, s_rsel;
    logic [NREG-1:0] commit;
    logic [DW-1:0]   regs [NREG];
    logic [DW-1:0]   h_rd_n, s_rd_n;
    logic            wake_q;

    mbx_decode #(.AW(AW), .NREG(NREG), .BASE(BASE)) u_hdec (
        .wr(h_wr), .rd(h_rd), .addr(h_addr), .wr_sel(h_wsel), .rd_sel(h_rsel)
    );

    mbx_decode #(.AW(AW), .NREG(NREG), .BASE(BASE)) u_sdec (
        .wr(s_wr), .rd(s_rd), .addr(s_addr), .wr_sel(s_wsel), .rd_sel(s_rsel)
    );

    for (genvar i = 0; i < NREG; i++) begin : g_cell
        mbx_cell #(.DW(DW)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .h_we    (h_wsel[i]),
            .h_be    (h_be),
            .h_wd    (h_wdata),
            .s_we    (s_wsel[i]),
            .s_be    (s_be),
            .s_wd    (s_wdata),
            .h_re    (h_rsel[i]),
            .s_re    (s_rsel[i]),
            .q       (regs[i]),
            .h_dirty (h_posted[i]),
            .s_dirty (s_posted[i]),
            .h_commit(commit[i])
        );
    end

    always_comb begin
        h_rd_n = '0;
        s_rd_n = '0;
        for (int i = 0; i < NREG; i++) begin
            if (h_rsel[i]) h_rd_n = h_rd_n | regs[i];
            if (s_rsel[i]) s_rd_n = s_rd_n | regs[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_rdata <= '0;
            s_rdata <= '0;
            wake_q  <= 1'b0;
        end else begin
            h_rdata <= h_rd_n;
            s_rdata <= s_rd_n;
            wake_q  <= |commit;
        end
    end

    assign wake = {NSEC{wake_q}};

    // R4: a host change is followed by a wake pulse
    a_r4_wake_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (|commit) |=> wake[0]);

    // R4: no wake without a host change the cycle before
    a_r4_wake_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !(|commit) |=> !wake[0]);

    // R1: a strobe reaches at most one register
    a_r1_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(h_wsel) && $onehot0(s_wsel));

    // R4: both secondaries see the same pulse
    always_comb a_r4_wake_both: assert (wake == '0 || wake == '1);

endmodule

// File: tb/mbx_bank_tb_top.sv
module mbx_bank_tb_top;
    localparam int CLK_P = 10;

    localparam int K_HRD = 0;
    localparam int K_SRD = 1;
    localparam int K_HP  = 2;
    localparam int K_SP  = 3;
    localparam int K_WK  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_wr = 0, h_rd = 0, s_wr = 0, s_rd = 0;
    logic [5:0]  h_addr = '0, s_addr = '0;
    logic [1:0]  h_be = '0, s_be = '0;
    logic [15:0] h_wdata = '0, s_wdata = '0;
    logic [15:0] h_rdata, s_rdata;
    logic [7:0]  h_posted, s_posted;
    logic [1:0]  wake;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        int          due;
        int          kind;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mbx_bank dut_i (
        .clk(clk), .rst_n(rst_n),
        .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr), .h_be(h_be),
        .h_wdata(h_wdata), .h_rdata(h_rdata),
        .s_wr(s_wr), .s_rd(s_rd), .s_addr(s_addr), .s_be(s_be),
        .s_wdata(s_wdata), .s_rdata(s_rdata),
        .h_posted(h_posted), .s_posted(s_posted), .wake(wake)
    );

    function automatic logic [15:0] observe(int kind);
        case (kind)
            K_HRD:   return h_rdata;
            K_SRD:   return s_rdata;
            K_HP:    return {8'h00, h_posted};
            K_SP:    return {8'h00, s_posted};
            default: return {14'h0, wake};
        endcase
    endfunction

    // Monitor: compare every item due in this cycle.
    always begin
        @(posedge clk);
        #(CLK_P/4);
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due <= cyc) begin
                logic [15:0] act;
                act = observe(sb[i].kind);
                n_run++;
                if (sb[i].due < cyc || act !== sb[i].exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", sb[i].tag, act, sb[i].exp);
                end
                sb.delete(i);
            end
        end
    end

    task automatic expect_at(int dly, int kind, logic [15:0] v, string tag);
        item_t it;
        it.due = cyc + dly;
        it.kind = kind;
        it.exp = v;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic go(logic hw, logic hr, logic [5:0] ha, logic [1:0] hb, logic [15:0] hd,
                      logic sw, logic sr, logic [5:0] sa, logic [1:0] sbe, logic [15:0] sd);
        @(negedge clk);
        h_wr = hw; h_rd = hr; h_addr = ha; h_be = hb; h_wdata = hd;
        s_wr = sw; s_rd = sr; s_addr = sa; s_be = sbe; s_wdata = sd;
    endtask

    task automatic idle();
        go(0, 0, 6'h00, 2'b00, 16'h0, 0, 0, 6'h00, 2'b00, 16'h0);
    endtask
    task automatic hwr(logic [5:0] a, logic [1:0] b, logic [15:0] d);
        go(1, 0, a, b, d, 0, 0, 6'h00, 2'b00, 16'h0);
    endtask
    task automatic hrd(logic [5:0] a);
        go(0, 1, a, 2'b00, 16'h0, 0, 0, 6'h00, 2'b00, 16'h0);
    endtask
    task automatic swr(logic [5:0] a, logic [1:0] b, logic [15:0] d);
        go(0, 0, 6'h00, 2'b00, 16'h0, 1, 0, a, b, d);
    endtask
    task automatic srd(logic [5:0] a);
        go(0, 0, 6'h00, 2'b00, 16'h0, 0, 1, a, 2'b00, 16'h0);
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R9: state held in reset
        repeat (2) @(negedge clk);
        expect_at(1, K_HP, 16'h0000, "R9 reset host flags");
        expect_at(1, K_SP, 16'h0000, "R9 reset sec flags");
        expect_at(1, K_WK, 16'h0000, "R9 reset wake");
        @(negedge clk);
        rst_n = 1'b1;
        hrd(6'h26);
        expect_at(1, K_HRD, 16'h0000, "R9 reset reg3 zero");

        // R2 / R4: host change on reg2
        hwr(6'h24, 2'b11, 16'hA55A);
        expect_at(1, K_HP, 16'h0004, "R2 host flag set");
        expect_at(1, K_WK, 16'h0003, "R4 wake high");
        expect_at(2, K_WK, 16'h0000, "R4 wake one cycle");
        idle();
        // R7: secondary read returns data and clears host flag
        srd(6'h24);
        expect_at(1, K_SRD, 16'hA55A, "R7 sec read data");
        expect_at(1, K_HP, 16'h0000, "R7 sec read clears host flag");

        // R3: same value dropped
        hwr(6'h24, 2'b11, 16'hA55A);
        expect_at(1, K_HP, 16'h0000, "R3 no flag on same value");
        expect_at(1, K_WK, 16'h0000, "R3 no wake on same value");

        // R6: low lane equal, high lane differs but disabled -> dropped
        hwr(6'h24, 2'b01, 16'h005A);
        expect_at(1, K_HP, 16'h0000, "R6 disabled lane ignored");
        expect_at(1, K_WK, 16'h0000, "R6 no wake");
        hwr(6'h24, 2'b10, 16'h3300);
        expect_at(1, K_HP, 16'h0004, "R6 high lane change flag");
        expect_at(1, K_WK, 16'h0003, "R6 high lane wake");
        hrd(6'h24);
        expect_at(1, K_HRD, 16'h335A, "R6 merged lanes");

        // R1: window decode
        hwr(6'h14, 2'b11, 16'h1111);
        expect_at(1, K_HP, 16'h0004, "R1 outside write no flag");
        expect_at(1, K_WK, 16'h0000, "R1 outside write no wake");
        hrd(6'h30);
        expect_at(1, K_HRD, 16'h0000, "R1 outside read zero");
        hwr(6'h2E, 2'b11, 16'h7777);
        expect_at(1, K_HP, 16'h0084, "R1 reg7 flag");
        hrd(6'h2F);
        expect_at(1, K_HRD, 16'h7777, "R1 odd address same reg");
        hrd(6'h14);
        expect_at(1, K_HRD, 16'h0000, "R1 outside write left nothing");

        // R7 / R5: secondary post and host read clear
        swr(6'h2A, 2'b11, 16'h1234);
        expect_at(1, K_SP, 16'h0020, "R7 sec flag set");
        expect_at(1, K_WK, 16'h0000, "R7 sec write no wake");
        hrd(6'h2A);
        expect_at(1, K_HRD, 16'h1234, "R5 host read data");
        expect_at(1, K_SP, 16'h0000, "R5 host read clears sec flag");

        // R10: set beats clear, read sees old value
        go(0, 1, 6'h22, 2'b00, 16'h0, 1, 0, 6'h22, 2'b11, 16'hBEEF);
        expect_at(1, K_HRD, 16'h0000, "R10 read old value");
        expect_at(1, K_SP, 16'h0002, "R10 sec set wins");
        hrd(6'h22);
        expect_at(1, K_HRD, 16'hBEEF, "R10 new value");
        expect_at(1, K_SP, 16'h0000, "R10 later clear");

        // R8: collision
        hwr(6'h28, 2'b11, 16'h0101);
        expect_at(1, K_HP, 16'h0094, "R8 prior host flag");
        go(1, 0, 6'h28, 2'b11, 16'h4444, 1, 0, 6'h28, 2'b11, 16'h5555);
        expect_at(1, K_HP, 16'h0084, "R8 host flag cleared");
        expect_at(1, K_SP, 16'h0010, "R8 sec flag set");
        expect_at(1, K_WK, 16'h0000, "R8 no wake");
        hrd(6'h28);
        expect_at(1, K_HRD, 16'h5555, "R8 secondary wins");

        // R10 host side: host write with secondary read on reg7
        go(1, 0, 6'h2E, 2'b11, 16'h8888, 0, 1, 6'h2E, 2'b00, 16'h0);
        expect_at(1, K_SRD, 16'h7777, "R10 sec read old");
        expect_at(1, K_HP, 16'h0084, "R10 host set wins");
        srd(6'h2E);
        expect_at(1, K_SRD, 16'h8888, "R7 sec read new");
        expect_at(1, K_HP, 16'h0004, "R7 host flag cleared");

        // R9: reset in mid run
        idle();
        @(negedge clk);
        rst_n = 1'b0;
        expect_at(1, K_HP, 16'h0000, "R9 mid reset host flags");
        expect_at(1, K_SP, 16'h0000, "R9 mid reset sec flags");
        @(negedge clk);
        rst_n = 1'b1;
        hrd(6'h24);
        expect_at(1, K_HRD, 16'h0000, "R9 mid reset reg cleared");
        idle();
        repeat (3) @(negedge clk);

        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule